// File: doc/BRIEF.md
# Dual-Port DRAM Access Arbiter

This block decides which of two processor ports, or the internal refresh requester, owns a shared DRAM array in each clock cycle, and it drives the RAS strobe for the access that is running. Port A presents a chip select that is qualified by either an address strobe or an access request line. Port B presents a single request line that already includes its chip select. A lock input pins ownership to whichever port holds the grant. A precharge-done status input gates the start of every access and every refresh.

Ownership is sticky. The port that last owned the array keeps the grant after its access ends, and loses it only when the other port asks for the array while the owner is quiet and unlocked. Refresh outranks both ports. It waits for a running port access to finish, runs for a fixed number of cycles, and leaves the grant where it was. When Port B already owns the array, its access starts in the same cycle as its request. When Port B has to win the grant first, RAS follows one or two clock edges after the grant appears, chosen by a configuration input. All inputs are taken as synchronous to `clk`.

Top module: `twa_dram_arbiter`

## Requirements
- R1: While reset is asserted and the request inputs are low, `b_grant`, `ras` and `ref_busy` are all 0 and Port A owns the array.
- R2: A Port A request is `a_sel & (a_strobe | a_areq)`. When Port A owns an idle array and `pre_done` is 1, `ras` goes to 1 in the same cycle as that request. `ras` stays at 1 while the request holds, and goes to 0 in the cycle the request drops.
- R3: When an access ends, the grant stays with the port that owned it until the other port requests.
- R4: The grant moves to Port B at a rising edge where `b_req` is 1, the Port A request is 0 and `lock` is 0. `b_grant` reads 1 in the following cycle. It moves back to Port A at an edge where the Port A request is 1, `b_req` is 0 and `lock` is 0.
- R5: While `lock` is 1, `b_grant` does not change, whatever the other port requests.
- R6: When Port B owns an idle array, `pre_done` is 1 and no refresh is requested, `ras` goes to 1 in the same cycle as `b_req`. `ras` goes to 0 in the cycle `b_req` drops.
- R7: After Port B wins the grant, `ras` stays at 0 in the cycle the grant appears. With `b_late`=0, `ras` goes to 1 after the first following rising edge. With `b_late`=1, it goes to 1 after the second.
- R8: No access starts while `pre_done` is 0. A pending Port B access starts in the first cycle in which `pre_done` is 1.
- R9: A refresh request on an idle array beats both ports, and no port `ras` is started in that cycle. The refresh then holds `ref_busy` and `ras` at 1 for `REF_CYCLES` cycles (default 3).
- R10: A refresh request that arrives during a port access waits until that access ends. `b_grant` does not change across the refresh, so ownership returns to the port that held it before.
- R11: If Port A raises a new qualified strobe before the access request of its previous access drops, the access continues without a gap and Port A keeps the grant, even while `b_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Port A chip select |
| a_strobe | input | 1 | Port A address strobe |
| a_areq | input | 1 | Port A access request line |
| b_req | input | 1 | Port B access request (includes chip select) |
| lock | input | 1 | Pins the grant to its current owner |
| ref_req | input | 1 | Refresh request |
| pre_done | input | 1 | RAS precharge complete for the addressed bank |
| b_late | input | 1 | 0: Port B starts one edge after its grant; 1: two edges after |
| b_grant | output | 1 | 1 while Port B owns the array |
| ref_busy | output | 1 | 1 while a refresh runs |
| ras | output | 1 | Row address strobe, active high |

## Verification
The properties assume that every input is already synchronous to `clk`. They also assume that a port holds its request steady for the whole of its access, and that `b_late` changes only while no Port B grant is being delayed. The stimulus drives every input at the falling edge, keeps each request high until its access has been seen to end, and changes `b_late` only in cycles where the array is idle or owned by Port A. The precharge input is lowered only around a Port B start, so each property sees that status as a level that is stable over one cycle.

// File: rtl/twa_pkg.sv
package twa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_AACC  = 3'd1,
        ST_BWAIT = 3'd2,
        ST_BACC  = 3'd3,
        ST_REF   = 3'd4
    } twa_state_e;

    typedef enum logic {
        OWN_A = 1'b0,
        OWN_B = 1'b1
    } twa_owner_e;

endpackage

// File: rtl/twa_port_a_decode.sv
module twa_port_a_decode (
    input  logic a_sel,
    input  logic a_strobe,
    input  logic a_areq,
    output logic a_hit
);

    // A qualified Port A request needs the chip select plus either strobe form
    always_comb begin
        a_hit = a_sel & (a_strobe | a_areq);
    end

endmodule

// File: rtl/twa_load_sel.sv
module twa_load_sel #(
    parameter int CNT_W      = 2,
    parameter int REF_CYCLES = 3,
    parameter int B_DLY_FAST = 1,
    parameter int B_DLY_SLOW = 2
) (
    input  logic             b_late,
    output logic [CNT_W-1:0] b_load,
    output logic [CNT_W-1:0] ref_load
);

    localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(B_DLY_FAST - 1);
    localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(B_DLY_SLOW - 1);

    assign ref_load = CNT_W'(REF_CYCLES - 1);

    generate
        if (B_DLY_FAST == B_DLY_SLOW) begin : g_fixed
            logic unused_late;
            assign unused_late = b_late;
            assign b_load      = FAST_LD;
        end else begin : g_pick
            assign b_load = b_late ? SLOW_LD : FAST_LD;
        end
    endgenerate

endmodule

// File: rtl/twa_dram_arbiter.sv
module twa_dram_arbiter
    import twa_pkg::*;
#(
    parameter int REF_CYCLES = 3,
    parameter int B_DLY_FAST = 1,
    parameter int B_DLY_SLOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_sel,
    input  logic a_strobe,
    input  logic a_areq,
    input  logic b_req,
    input  logic lock,
    input  logic ref_req,
    input  logic pre_done,
    input  logic b_late,
    output logic b_grant,
    output logic ref_busy,
    output logic ras
);

    localparam int MAX_CNT = (REF_CYCLES > B_DLY_SLOW) ? REF_CYCLES : B_DLY_SLOW;
    localparam int CNT_W   = $clog2(MAX_CNT) + 1;

    typedef struct packed {
        twa_state_e       st;
        twa_owner_e       own;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t            r_d;
    regs_t            r_q;
    logic             a_hit;
    logic [CNT_W-1:0] b_load;
    logic [CNT_W-1:0] ref_load;
    logic             ras_d;
    logic             a_go;
    logic             b_go;

    twa_port_a_decode u_adec (
        .a_sel    (a_sel),
        .a_strobe (a_strobe),
        .a_areq   (a_areq),
        .a_hit    (a_hit)
    );

    twa_load_sel #(
        .CNT_W      (CNT_W),
        .REF_CYCLES (REF_CYCLES),
        .B_DLY_FAST (B_DLY_FAST),
        .B_DLY_SLOW (B_DLY_SLOW)
    ) u_ld (
        .b_late   (b_late),
        .b_load   (b_load),
        .ref_load (ref_load)
    );

    // Next-state computation
    always_comb begin
        r_d   = r_q;
        ras_d = 1'b0;
        a_go  = (r_q.own == OWN_A) && a_hit;
        b_go  = (r_q.own == OWN_B) && b_req;

        case (r_q.st)
            ST_IDLE: begin
                if (ref_req) begin
                    // refresh outranks both ports; it waits for precharge only
                    if (pre_done) begin
                        r_d.st  = ST_REF;
                        r_d.cnt = ref_load;
                    end
                end else if (a_go || b_go) begin
                    // the owner starts at once when the bank is precharged
                    if (pre_done) begin
                        ras_d  = 1'b1;
                        r_d.st = a_go ? ST_AACC : ST_BACC;
                    end
                end else if ((r_q.own == OWN_A) && b_req && !a_hit && !lock) begin
                    r_d.own = OWN_B;
                    r_d.st  = ST_BWAIT;
                    r_d.cnt = b_load;
                end else if ((r_q.own == OWN_B) && a_hit && !b_req && !lock) begin
                    r_d.own = OWN_A;
                end
            end

            ST_AACC: begin
                ras_d = a_hit;
                if (!a_hit) begin
                    r_d.st = ST_IDLE;
                end
            end

            ST_BWAIT: begin
                if (ref_req) begin
                    if (pre_done) begin
                        r_d.st  = ST_REF;
                        r_d.cnt = ref_load;
                    end
                end else if (!b_req) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (pre_done) begin
                    r_d.st = ST_BACC;
                end
            end

            ST_BACC: begin
                ras_d = b_req;
                if (!b_req) begin
                    r_d.st = ST_IDLE;
                end
            end

            ST_REF: begin
                ras_d = 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.own <= OWN_A;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ras      = ras_d;
    assign b_grant  = (r_q.own == OWN_B);
    assign ref_busy = (r_q.st == ST_REF);

endmodule

// File: rtl/twa_dram_arbiter_chk.sv
module twa_dram_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic a_sel,
    input logic a_strobe,
    input logic a_areq,
    input logic b_req,
    input logic lock,
    input logic ref_req,
    input logic pre_done,
    input logic b_late,
    input logic b_grant,
    input logic ref_busy,
    input logic ras
);

    logic a_rq;
    assign a_rq = a_sel && (a_strobe || a_areq);

    // R4: Port B only gains the grant after an edge with B asking, A quiet, no lock
    a_r4_grant_to_b: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_grant) |-> $past(b_req && !a_rq && !lock));

    // R4: Port A only takes the grant back when it asks while B is quiet and unlocked
    a_r4_grant_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_grant) |-> $past(a_rq && !b_req && !lock));

    // R5: a locked grant stays where it is
    a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(b_grant));

    // R7: RAS is never raised in the cycle a new Port B grant appears
    a_r7_no_early_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_grant) |-> !ras);

    // R8: every RAS rise follows a precharged bank
    a_r8_precharged: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras) |-> (pre_done || $past(pre_done)));

    // R9: refresh always drives RAS
    a_r9_ref_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> ras);

    // R10: ownership is untouched by a refresh
    a_r10_ref_keeps_owner: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> $stable(b_grant));

    // R1: quiet outputs under reset
    always @(negedge clk) begin
        if (!rst_n && !ref_req && !b_req && !(a_sel && (a_strobe || a_areq))) begin
            a_r1_reset_quiet: assert (!b_grant && !ras && !ref_busy);
        end
    end

endmodule

bind twa_dram_arbiter twa_dram_arbiter_chk chk_i (.*);

// File: tb/twa_dram_arbiter_tb_top.sv
`timescale 1ns/100ps
module twa_dram_arbiter_tb_top;

    typedef struct {
        bit    e_ras;
        bit    e_bg;
        bit    e_rf;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_sel = 1'b0, a_strobe = 1'b0, a_areq = 1'b0;
    logic b_req = 1'b0, lock = 1'b0, ref_req = 1'b0;
    logic pre_done = 1'b1, b_late = 1'b0;
    logic b_grant, ref_busy, ras;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    bit   done   = 1'b0;

    always #2.5 clk = ~clk;

    twa_dram_arbiter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_sel    (a_sel),
        .a_strobe (a_strobe),
        .a_areq   (a_areq),
        .b_req    (b_req),
        .lock     (lock),
        .ref_req  (ref_req),
        .pre_done (pre_done),
        .b_late   (b_late),
        .b_grant  (b_grant),
        .ref_busy (ref_busy),
        .ras      (ras)
    );

    // Driver: apply one cycle of inputs and queue the expected outputs
    task automatic cyc(input logic s, st, rq, b, lk, rf, pd,
                       input bit e_ras, e_bg, e_rf, input string tag);
        exp_t it;
        @(negedge clk);
        a_sel = s; a_strobe = st; a_areq = rq;
        b_req = b; lock = lk; ref_req = rf; pre_done = pd;
        it.e_ras = e_ras; it.e_bg = e_bg; it.e_rf = e_rf; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare shortly before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                checks++;
                if (ras !== it.e_ras || b_grant !== it.e_bg || ref_busy !== it.e_rf) begin
                    errors++;
                    $display("FAIL %s: ras/b_grant/ref_busy = %0b%0b%0b expected %0b%0b%0b",
                             it.tag, ras, b_grant, ref_busy, it.e_ras, it.e_bg, it.e_rf);
                end
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: cycles=%0d expected completion", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        // R1 reset state
        cyc(0,0,0,0,0,0,1, 0,0,0, "R1");
        cyc(0,0,0,0,0,0,1, 0,0,0, "R1");
        cyc(0,0,0,0,0,0,1, 0,0,0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R2 Port A access, both strobe forms
        cyc(1,1,0,0,0,0,1, 1,0,0, "R2");
        cyc(1,0,1,0,0,0,1, 1,0,0, "R2");
        cyc(0,0,0,0,0,0,1, 0,0,0, "R2");
        // R4 / R7 Port B wins grant, early start
        cyc(0,0,0,1,0,0,1, 0,0,0, "R4");
        cyc(0,0,0,1,0,0,1, 0,1,0, "R4");
        cyc(0,0,0,1,0,0,1, 1,1,0, "R7");
        cyc(0,0,0,0,0,0,1, 0,1,0, "R6");
        cyc(0,0,0,0,0,0,1, 0,1,0, "R3");
        // R6 owner fast path
        cyc(0,0,0,1,0,0,1, 1,1,0, "R6");
        cyc(0,0,0,1,0,0,1, 1,1,0, "R6");
        cyc(0,0,0,0,0,0,1, 0,1,0, "R6");
        // R4 Port A reclaims
        cyc(1,1,0,0,0,0,1, 0,1,0, "R4");
        cyc(1,1,0,0,0,0,1, 1,0,0, "R2");
        cyc(0,0,0,0,0,0,1, 0,0,0, "R2");
        // R5 lock, then R7 late start
        b_late = 1'b1;
        cyc(0,0,0,1,1,0,1, 0,0,0, "R5");
        cyc(0,0,0,1,1,0,1, 0,0,0, "R5");
        cyc(0,0,0,1,0,0,1, 0,0,0, "R4");
        cyc(0,0,0,1,0,0,1, 0,1,0, "R7");
        cyc(0,0,0,1,0,0,1, 0,1,0, "R7");
        cyc(0,0,0,1,0,0,1, 1,1,0, "R7");
        cyc(0,0,0,0,0,0,1, 0,1,0, "R6");
        cyc(1,1,0,0,1,0,1, 0,1,0, "R5");
        cyc(1,1,0,0,1,0,1, 0,1,0, "R5");
        cyc(0,0,0,0,0,0,1, 0,1,0, "R3");
        // R9 refresh beats owner B, R10 grant kept
        cyc(0,0,0,1,0,1,1, 0,1,0, "R9");
        cyc(0,0,0,1,0,0,1, 1,1,1, "R9");
        cyc(0,0,0,1,0,0,1, 1,1,1, "R9");
        cyc(0,0,0,1,0,0,1, 1,1,1, "R9");
        cyc(0,0,0,1,0,0,1, 1,1,0, "R10");
        cyc(0,0,0,0,0,0,1, 0,1,0, "R6");
        // R10 refresh waits for Port A access
        cyc(1,1,0,0,0,0,1, 0,1,0, "R4");
        cyc(1,0,1,0,0,0,1, 1,0,0, "R2");
        cyc(1,0,1,0,0,1,1, 1,0,0, "R10");
        cyc(0,0,0,0,0,1,1, 0,0,0, "R10");
        cyc(0,0,0,0,0,1,1, 0,0,0, "R9");
        cyc(0,0,0,0,0,0,1, 1,0,1, "R9");
        cyc(0,0,0,0,0,0,1, 1,0,1, "R9");
        cyc(0,0,0,0,0,0,1, 1,0,1, "R9");
        cyc(0,0,0,0,0,0,1, 0,0,0, "R10");
        // R11 interleaved Port A access with B waiting
        b_late = 1'b0;
        cyc(1,1,0,0,0,0,1, 1,0,0, "R11");
        cyc(1,0,1,1,0,0,1, 1,0,0, "R11");
        cyc(1,1,1,1,0,0,1, 1,0,0, "R11");
        cyc(1,1,0,1,0,0,1, 1,0,0, "R11");
        cyc(0,0,0,1,0,0,1, 0,0,0, "R11");
        cyc(0,0,0,1,0,0,1, 0,0,0, "R4");
        cyc(0,0,0,1,0,0,1, 0,1,0, "R7");
        cyc(0,0,0,1,0,0,1, 1,1,0, "R7");
        cyc(0,0,0,0,0,0,1, 0,1,0, "R6");
        // R8 precharge gate
        cyc(0,0,0,1,0,0,0, 0,1,0, "R8");
        cyc(0,0,0,1,0,0,0, 0,1,0, "R8");
        cyc(0,0,0,1,0,0,1, 1,1,0, "R8");
        cyc(0,0,0,0,0,0,1, 0,1,0, "R8");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule